// File: doc/BRIEF.md
# Integer and Fractional Divide Unit

This unit is an iterative restoring divider. It produces one quotient bit per clock and serves four operations, chosen by `op_sel`. The operations are a 16-by-16 unsigned integer divide, a 16-by-16 unsigned fractional divide, and a 32-by-16 extended divide in unsigned and signed forms. Every operation yields a 16-bit quotient, a 16-bit remainder and three flags:

- zero (`flag_z`)
- overflow (`flag_v`)
- zero divisor (`flag_c`)

In fractional mode the numerator is treated as if shifted left by sixteen places. The binary point of the quotient therefore sits just above its most significant bit. Feeding the remainder back in as the next numerator, with the same divisor, continues the fraction for another sixteen bits.

A caller presents the operands and pulses `start` while `busy` is low. The unit does the following:

- It spends one setup cycle conditioning the operands and checking for failure.
- It spends sixteen iteration cycles on the quotient bits.
- It spends one finish cycle fixing signs and flags, then raises `done` for one cycle.

Failures that are visible from the operands end the operation right after setup. Every failure returns an all-ones quotient and a zero remainder. The results stay on the outputs until the next `done`.

Top module: `qdiv_unit`

## Requirements
- R1: With `op_sel`=0 (integer), the quotient is `dividend[15:0]` divided by `divisor` (rounded down) and the remainder is the modulus. The remainder is always smaller than the divisor.
- R2: With `op_sel`=1 (fractional) and a numerator `dividend[15:0]` smaller than the divisor, the quotient is (numerator·65536)/divisor and the remainder is (numerator·65536) mod divisor. For example, 0x3000/0x4000 gives 0xC000.
- R3: In fractional mode, a numerator greater than or equal to the divisor sets V and returns quotient 0xFFFF with remainder 0.
- R4: A zero divisor sets C and returns quotient 0xFFFF with remainder 0. V is 0 in integer mode and 1 in the other three modes.
- R5: Z is 1 exactly when a successful operation returns a zero quotient. Z is 0 on every failure.
- R6: With `op_sel`=2 (extended unsigned), the full 32-bit dividend is divided by the divisor. A true quotient above 0xFFFF sets V and returns 0xFFFF and 0.
- R7: With `op_sel`=3 (extended signed), operands are two's complement. The quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend.
- R8: In signed mode, a true quotient whose magnitude exceeds 0x7FFF sets V and returns 0xFFFF and 0. This includes a result of −32768.
- R9: `done` lasts exactly one cycle. It rises 18 clock edges after the edge that samples `start` when all 16 iterations run. It rises after 2 edges when a zero divisor, a fractional numerator that is too large, or a quotient above 16 bits is seen in setup.
- R10: `busy` is high from the edge that samples `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored.
- R11: After reset all outputs are 0. Quotient, remainder and flags change only in the cycle `done` rises.
- R12: A fractional remainder fed back as the numerator, with the same divisor, yields the next 16 fraction bits. For example, 1/3 gives quotient 0x5555 and remainder 1, twice in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_sel | input | 2 | 0 integer, 1 fractional, 2 extended unsigned, 3 extended signed |
| dividend | input | 32 | Dividend; the 16-bit modes use bits 15:0 |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 16 | Quotient, or 0xFFFF on failure |
| remainder | output | 16 | Remainder, or 0 on failure |
| flag_z | output | 1 | Quotient is zero |
| flag_v | output | 1 | Overflow or fractional failure |
| flag_c | output | 1 | Divisor was zero |

## Verification
The bound assertions watch the following on every cycle:

- the one-cycle shape of `done` and that it ends the `busy` window;
- the two allowed run lengths;
- the 0xFFFF/0 failure pattern whenever C or V is raised;
- the bound of the remainder against the latched divisor in the unsigned modes;
- the holding of results between strobes.

The arithmetic values themselves can only be shown by the bench's scenarios. These cover the signed quotient and remainder rules, the boundary at a 0x7FFF magnitude, the largest unsigned extended quotient, fractional chaining and a `start` pulse during a running operation.

// File: rtl/qdiv_pkg.sv
// Shared types for the divide unit: operation codes and control states.
package qdiv_pkg;

    // Operation select; the encoding is visible at the op_sel port.
    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_FRAC = 2'd1,
        OP_EXTU = 2'd2,
        OP_EXTS = 2'd3
    } div_op_e;

    // Control sequence: one setup, QW iterations, one finish.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ITER   = 2'd2,
        ST_FINISH = 2'd3
    } div_state_e;

endpackage

// File: rtl/qdiv_prep.sv
// Operand conditioning (combinational).
// Places the numerator in a 2*QW-bit frame for the selected mode. In signed
// mode it takes operand magnitudes and records the sign corrections.
// It also flags any failure that is visible before iterating.
// Assumes the operands are held stable in the caller's registers.
module qdiv_prep
    import qdiv_pkg::*;
#(
    parameter int QW = 16
) (
    input  div_op_e            op,
    input  logic [2*QW-1:0]    dvd,
    input  logic [QW-1:0]      dvs,
    output logic [QW-1:0]      num_hi,
    output logic [QW-1:0]      num_lo,
    output logic [QW-1:0]      den,
    output logic               neg_quo,
    output logic               neg_rem,
    output logic               zero_div,
    output logic               early_fail,
    output logic               early_v
);
    localparam int DW = 2 * QW;

    logic [DW-1:0] dvd_mag;
    logic [QW-1:0] dvs_mag;

    // Magnitudes used by the signed mode.
    always_comb begin
        dvd_mag = dvd[DW-1] ? (~dvd + 1'b1) : dvd;
        dvs_mag = dvs[QW-1] ? (~dvs + 1'b1) : dvs;
    end

    // Numerator framing and denominator selection per mode.
    always_comb begin
        num_hi  = '0;
        num_lo  = '0;
        den     = dvs;
        neg_quo = 1'b0;
        neg_rem = 1'b0;
        unique case (op)
            OP_INT: begin
                num_lo = dvd[QW-1:0];
            end
            OP_FRAC: begin
                num_hi = dvd[QW-1:0];
            end
            OP_EXTU: begin
                num_hi = dvd[DW-1:QW];
                num_lo = dvd[QW-1:0];
            end
            default: begin
                num_hi  = dvd_mag[DW-1:QW];
                num_lo  = dvd_mag[QW-1:0];
                den     = dvs_mag;
                neg_quo = dvd[DW-1] ^ dvs[QW-1];
                neg_rem = dvd[DW-1];
            end
        endcase
    end

    // Failure visible from the operands: zero divisor, or quotient wider than QW.
    always_comb begin
        zero_div   = (dvs == '0);
        early_fail = zero_div || (num_hi >= den);
        early_v    = early_fail && (op != OP_INT);
    end

endmodule

// File: rtl/qdiv_core.sv
// Restoring divide datapath: one quotient bit per step.
// Assumes num_hi < den at load, so every partial remainder fits in QW bits.
// After QW steps, quo_mag holds the quotient and rem_mag the remainder.
module qdiv_core #(
    parameter int QW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [QW-1:0]  num_hi,
    input  logic [QW-1:0]  num_lo,
    input  logic [QW-1:0]  den,
    output logic [QW-1:0]  quo_mag,
    output logic [QW-1:0]  rem_mag,
    output logic           last_step
);
    localparam int CW = $clog2(QW + 1);

    logic [QW-1:0] rem_q;
    logic [QW-1:0] shq_q;
    logic [CW-1:0] cnt_q;
    logic [QW:0]   trial;
    logic [QW+1:0] diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, shq_q[QW-1]};
        diff  = {1'b0, trial} - {2'b00, den};
        fits  = ~diff[QW+1];
    end

    // Partial remainder and quotient shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            shq_q <= '0;
        end else if (load) begin
            rem_q <= num_hi;
            shq_q <= num_lo;
        end else if (step) begin
            rem_q <= fits ? diff[QW-1:0] : trial[QW-1:0];
            shq_q <= {shq_q[QW-2:0], fits};
        end
    end

    // Iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign last_step = step && (cnt_q == CW'(QW - 1));
    assign quo_mag   = shq_q;
    assign rem_mag   = rem_q;

endmodule

// File: rtl/qdiv_post.sv
// Result correction (combinational).
// Applies the signed-mode sign rules and flags signed quotients whose
// magnitude does not fit in QW-1 bits. Assumes the sign flags are zero
// outside signed mode.
module qdiv_post
    import qdiv_pkg::*;
#(
    parameter int QW = 16
) (
    input  div_op_e        op,
    input  logic [QW-1:0]  quo_mag,
    input  logic [QW-1:0]  rem_mag,
    input  logic           neg_quo,
    input  logic           neg_rem,
    output logic [QW-1:0]  quo_fin,
    output logic [QW-1:0]  rem_fin,
    output logic           late_ovf
);
    // Sign fix-up and signed magnitude overflow.
    always_comb begin
        quo_fin  = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_fin  = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
        late_ovf = (op == OP_EXTS) && quo_mag[QW-1];
    end

endmodule

// File: rtl/qdiv_unit.sv
// Integer / fractional / extended divide unit (top).
// Sequences setup, QW restoring iterations and a finish cycle. It registers
// the results and flags, which hold until the next done pulse.
// Assumes start is only acted on while idle; operands are captured at start.
module qdiv_unit
    import qdiv_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic [2*QW-1:0]   dividend,
    input  logic [QW-1:0]     divisor,
    output logic              busy,
    output logic              done,
    output logic [QW-1:0]     quotient,
    output logic [QW-1:0]     remainder,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    localparam int DW = 2 * QW;

    div_state_e    state_q;
    div_op_e       op_q;
    logic [DW-1:0] dvd_q;
    logic [QW-1:0] dvs_q;
    logic          fail_q, failv_q, failc_q;

    logic [QW-1:0] num_hi, num_lo, den;
    logic          neg_quo, neg_rem, zero_div, early_fail, early_v;
    logic [QW-1:0] quo_mag, rem_mag, quo_fin, rem_fin;
    logic          last_step, late_ovf;
    logic          core_load, core_step;

    qdiv_prep #(.QW(QW)) u_prep (
        .op(op_q), .dvd(dvd_q), .dvs(dvs_q),
        .num_hi(num_hi), .num_lo(num_lo), .den(den),
        .neg_quo(neg_quo), .neg_rem(neg_rem), .zero_div(zero_div),
        .early_fail(early_fail), .early_v(early_v)
    );

    assign core_load = (state_q == ST_SETUP) && !early_fail;
    assign core_step = (state_q == ST_ITER);

    qdiv_core #(.QW(QW)) u_core (
        .clk(clk), .rst_n(rst_n), .load(core_load), .step(core_step),
        .num_hi(num_hi), .num_lo(num_lo), .den(den),
        .quo_mag(quo_mag), .rem_mag(rem_mag), .last_step(last_step)
    );

    qdiv_post #(.QW(QW)) u_post (
        .op(op_q), .quo_mag(quo_mag), .rem_mag(rem_mag),
        .neg_quo(neg_quo), .neg_rem(neg_rem),
        .quo_fin(quo_fin), .rem_fin(rem_fin), .late_ovf(late_ovf)
    );

    // Control sequence and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_INT;
            dvd_q   <= '0;
            dvs_q   <= '0;
            fail_q  <= 1'b0;
            failv_q <= 1'b0;
            failc_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q    <= div_op_e'(op_sel);
                    dvd_q   <= dividend;
                    dvs_q   <= divisor;
                    state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    fail_q  <= early_fail;
                    failv_q <= early_v;
                    failc_q <= zero_div;
                    state_q <= early_fail ? ST_FINISH : ST_ITER;
                end
                ST_ITER: if (last_step) state_q <= ST_FINISH;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers, loaded only in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_FINISH) begin
                done <= 1'b1;
                if (fail_q || late_ovf) begin
                    quotient  <= '1;
                    remainder <= '0;
                    flag_z    <= 1'b0;
                    flag_v    <= fail_q ? failv_q : 1'b1;
                    flag_c    <= fail_q ? failc_q : 1'b0;
                end else begin
                    quotient  <= quo_fin;
                    remainder <= rem_fin;
                    flag_z    <= (quo_fin == '0);
                    flag_v    <= 1'b0;
                    flag_c    <= 1'b0;
                end
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/qdiv_unit_chk.sv
// Protocol and result-shape checks for qdiv_unit, attached by bind.
module qdiv_unit_chk #(
    parameter int QW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [1:0]     op_sel,
    input logic [QW-1:0]  divisor,
    input logic           busy,
    input logic           done,
    input logic [QW-1:0]  quotient,
    input logic [QW-1:0]  remainder,
    input logic           flag_v,
    input logic           flag_c
);
    localparam int LONG_RUN  = QW + 2;
    localparam int SHORT_RUN = 2;
    localparam int RW        = $clog2(LONG_RUN + 2);

    logic [RW-1:0] run_len;
    logic [1:0]    lat_op;
    logic [QW-1:0] lat_dvs;

    // Count busy cycles of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_len <= '0;
        else if (start && !busy)   run_len <= '0;
        else if (busy)             run_len <= run_len + 1'b1;
    end

    // Keep the accepted mode and divisor for the result checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op  <= '0;
            lat_dvs <= '0;
        end else if (start && !busy) begin
            lat_op  <= op_sel;
            lat_dvs <= divisor;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RW'(LONG_RUN) || run_len == RW'(SHORT_RUN)));

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_c) |-> (quotient == '1 && remainder == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (quotient == '1 && remainder == '0));

    // R1
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_v && !flag_c && lat_op != 2'd3) |-> (remainder < lat_dvs));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind qdiv_unit qdiv_unit_chk #(.QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/qdiv_unit_tb.sv
// Scoreboard bench for qdiv_unit: the driver queues expected results, the monitor compares.
module qdiv_unit_tb;
    typedef struct packed {
        logic [15:0] q;
        logic [15:0] r;
        logic        z;
        logic        v;
        logic        c;
        int          lat;
        int          cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, flag_z, flag_v, flag_c;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qdiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [1:0] op, input logic [31:0] dvd,
                                   input logic [15:0] dvs);
        exp_t e;
        longint n, q, r, sn, sd, mn, md;
        bit fail;
        e = '0; e.lat = 18; fail = 0; q = 0; r = 0;
        case (op)
            2'd0: begin
                if (dvs == 0) begin fail = 1; e.c = 1; e.lat = 2; end
                else begin q = longint'(dvd[15:0]) / longint'(dvs); r = longint'(dvd[15:0]) % longint'(dvs); end
            end
            2'd1: begin
                n = longint'(dvd[15:0]);
                if (dvs == 0) begin fail = 1; e.v = 1; e.c = 1; e.lat = 2; end
                else if (n >= longint'(dvs)) begin fail = 1; e.v = 1; e.lat = 2; end
                else begin q = (n * 65536) / longint'(dvs); r = (n * 65536) % longint'(dvs); end
            end
            2'd2: begin
                n = longint'(dvd);
                if (dvs == 0) begin fail = 1; e.v = 1; e.c = 1; e.lat = 2; end
                else if (n / longint'(dvs) > 65535) begin fail = 1; e.v = 1; e.lat = 2; end
                else begin q = n / longint'(dvs); r = n % longint'(dvs); end
            end
            default: begin
                sn = longint'($signed(dvd));
                sd = longint'($signed(dvs));
                if (sd == 0) begin fail = 1; e.v = 1; e.c = 1; e.lat = 2; end
                else begin
                    mn = (sn < 0) ? -sn : sn;
                    md = (sd < 0) ? -sd : sd;
                    q = mn / md; r = mn % md;
                    if (q > 65535) begin fail = 1; e.v = 1; e.lat = 2; end
                    else if (q > 32767) begin fail = 1; e.v = 1; end
                    else begin
                        if ((sn < 0) != (sd < 0)) q = -q;
                        if (sn < 0) r = -r;
                    end
                end
            end
        endcase
        if (fail) begin e.q = 16'hFFFF; e.r = 16'h0000; e.z = 0; end
        else begin e.q = q[15:0]; e.r = r[15:0]; e.z = (q[15:0] == 16'h0); end
        return e;
    endfunction

    task automatic check(input string tag, input logic ok, input string got, input string want);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, got, want);
        end
    endtask

    // Driver: queue the expectation, pulse start, wait for the result.
    task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] dvd,
                          input logic [15:0] dvs, input bit poke);
        exp_t e;
        e = model(op, dvd, dvs);
        e.cyc = cyc + 1 + e.lat;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        op_sel = op; dividend = dvd; divisor = dvs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R10 busy after start"}, busy === 1'b1, $sformatf("%b", busy), "1");
        if (poke) begin
            repeat (4) @(negedge clk);
            op_sel = 2'd0; dividend = 32'd9; divisor = 16'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        check({tag, " R10 idle after done"}, busy === 1'b0 && done === 1'b0,
              $sformatf("busy=%b done=%b", busy, done), "busy=0 done=0");
    endtask

    // Monitor: compare each done against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected done", 1'b0, "done", "no result");
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, quotient === e.q && remainder === e.r && flag_z === e.z &&
                         flag_v === e.v && flag_c === e.c && cyc == e.cyc,
                      $sformatf("q=%h r=%h z%b v%b c%b cyc=%0d", quotient, remainder, flag_z, flag_v, flag_c, cyc),
                      $sformatf("q=%h r=%h z%b v%b c%b cyc=%0d", e.q, e.r, e.z, e.v, e.c, e.cyc));
            end
        end
    end

    initial begin
        logic [15:0] hq, hr;
        repeat (3) @(negedge clk);
        check("R11 reset state", {busy, done, quotient, remainder, flag_z, flag_v, flag_c} === '0,
              $sformatf("q=%h r=%h", quotient, remainder), "all zero");
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R1 int 1000/7",          2'd0, 32'd1000, 16'd7, 0);
        run_op("R5 int zero quotient",   2'd0, 32'd5, 16'd9, 0);
        run_op("R1 int FFFF/1",          2'd0, 32'hFFFF, 16'd1, 0);
        run_op("R4 int zero divisor",    2'd0, 32'd1234, 16'd0, 0);
        run_op("R2 frac 0.75",           2'd1, 32'h3000, 16'h4000, 0);
        run_op("R12 frac 1/3 first",     2'd1, 32'd1, 16'd3, 0);
        run_op("R12 frac 1/3 chained",   2'd1, {16'h0, remainder}, 16'd3, 0);
        run_op("R3 frac equal",          2'd1, 32'd5, 16'd5, 0);
        run_op("R5 frac zero numerator", 2'd1, 32'd0, 16'd7, 0);
        run_op("R4 frac zero divisor",   2'd1, 32'd9, 16'd0, 0);
        run_op("R6 extu general",        2'd2, 32'h12345678, 16'h4321, 0);
        run_op("R6 extu overflow",       2'd2, 32'h00010000, 16'd1, 0);
        run_op("R6 extu max quotient",   2'd2, 32'hFFFE0001, 16'hFFFF, 0);
        run_op("R7 exts neg/pos",        2'd3, -32'sd1000, 16'd7, 0);
        run_op("R7 exts pos/neg",        2'd3, 32'd1000, -16'sd7, 0);
        run_op("R7 exts neg/neg",        2'd3, -32'sd1000, -16'sd7, 0);
        run_op("R8 exts 0x8000",         2'd3, 32'h8000, 16'd1, 0);
        run_op("R8 exts -32768",         2'd3, -32'sd32768, 16'd1, 0);
        run_op("R8 exts 0x7FFF",         2'd3, 32'h7FFF, 16'd1, 0);
        run_op("R8 exts wide quotient",  2'd3, 32'h00100000, 16'd1, 0);
        run_op("R4 exts zero divisor",   2'd3, 32'd77, 16'd0, 0);
        run_op("R10 start while busy",   2'd2, 32'h00ABCDEF, 16'h0123, 1);

        hq = quotient; hr = remainder;
        dividend = 32'hDEAD; divisor = 16'h0; op_sel = 2'd3;
        repeat (5) @(negedge clk);
        check("R11 results hold", quotient === hq && remainder === hr && done === 1'b0,
              $sformatf("q=%h r=%h", quotient, remainder), $sformatf("q=%h r=%h", hq, hr));
        check("R9 scoreboard drained", exp_q.size() == 0, $sformatf("%0d", exp_q.size()), "0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule